// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit decodes one 32-bit instruction word from a conditional-select family and executes it. It puts two register indices on its read-address outputs, takes the two operand words back in the same cycle, and tests a 4-bit condition code against the current N, Z, C and V flags. If the condition holds, the first operand is selected. If it fails, the second operand is selected after one of four transforms: pass-through, increment, bitwise inversion or two's-complement negation. A register index of 15 reads as the constant zero. Some reserved index and condition values are reported as undefined. Words outside the family are reported as non-matching.

Instructions enter on a valid/ready stream and results leave on a valid/ready stream, through one output register. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output field holds its value. The flags are only read and are never changed. Writing the result into the register file is left to the surrounding logic and is gated by `out_wen`.

Top module: `cs_unit`

## Requirements
- R1: A word belongs to the family only when bits[31:20] = 1110_1010_0101 and bits[15:14] = 10. Any other word gives `out_nomatch`=1, `out_wen`=0 and `out_result`=0.
- R2: A family word with rm (bits[3:0]) = 13 gives `out_nomatch`=1 and no write, with `out_undef`=0, even when other fields are illegal. The two flags are never high together.
- R3: A family word with rm≠13 and with rd (bits[11:8]) of 13 or 15, rn (bits[19:16]) of 13, or fcond (bits[7:4]) ≥ 14 gives `out_undef`=1, `out_wen`=0 and `out_result`=0.
- R4: `rn_addr` and `rm_addr` show bits[19:16] and bits[3:0]. An operand whose index is 15 is taken as zero, whatever its data input carries.
- R5: op (bits[13:12]) = 0: the result is Rn if the condition holds, else Rm.
- R6: op = 1: the result is Rn if the condition holds, else Rm+1 modulo 2^32 (0xFFFFFFFF gives 0).
- R7: op = 2: the result is Rn if the condition holds, else the bitwise NOT of Rm.
- R8: op = 3: the result is Rn if the condition holds, else −Rm modulo 2^32 (0x80000000 gives 0x80000000).
- R9: `in_flags` = {N,Z,C,V}. fcond codes: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). A true condition passes Rn unchanged.
- R10: A word is taken on an edge with `in_valid` & `in_ready`. `in_ready` = !`out_valid` | `out_ready`. Its result appears one edge later with `out_valid`=1, results keep their input order, and all outputs hold while `out_valid` & !`out_ready`.
- R11: A synchronous active-high reset clears `out_valid` and `out_wen`, even while `in_valid` is high. `out_wen` is never high without `out_valid`.
- R12: `out_rd` carries bits[11:8] of the word, and `out_wen`=1 exactly for family words that are neither non-matching nor undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and flags are valid |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_instr | input | 32 | Instruction word |
| in_flags | input | 4 | Condition flags {N,Z,C,V} |
| rn_addr | output | 4 | Read index for the first operand |
| rm_addr | output | 4 | Read index for the second operand |
| rn_data | input | 32 | First operand read data |
| rm_data | input | 32 | Second operand read data |
| out_valid | output | 1 | Result fields are valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Selected value |
| out_rd | output | 4 | Destination index |
| out_wen | output | 1 | Result should be written to out_rd |
| out_undef | output | 1 | Word is undefined |
| out_nomatch | output | 1 | Word is not of this family |

## Verification
All fourteen condition codes are run against all sixteen flag combinations with distinct operands, so every code's truth table is separated from its neighbours and from its inverse. Each transform is tried with its condition false, on values that tell the transforms apart and at the wrap points (all ones for increment, the most negative value for negation). It is also tried with the condition true, to show that Rn bypasses the transform. Index 15 is fed a non-zero data word on both operands, so a design that reads the data instead of zero is caught. Reserved indices, reserved conditions, broken fixed bits and rm=13 combined with other illegal fields show the flag priority. A phase with a randomly stalled consumer checks ordering and output holding.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int IDX_W = 4;
  localparam logic [11:0] HI_FIXED = 12'b1110_1010_0101;
  localparam logic [1:0]  MID_FIXED = 2'b10;
  localparam logic [IDX_W-1:0] IDX_ZERO = 4'd15;
  localparam logic [IDX_W-1:0] IDX_RSVD = 4'd13;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_INC  = 2'd1,
    OP_INV  = 2'd2,
    OP_NEG  = 2'd3
  } cs_op_e;

  typedef struct packed {
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
    logic [IDX_W-1:0] rd;
    logic [3:0]       fcond;
    cs_op_e           op;
    logic             nomatch;
    logic             undef;
  } cs_dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cs_flags_t;
endpackage

// File: rtl/cs_decode.sv
module cs_decode
  import cs_pkg::*;
(
  input  logic [31:0] instr,
  output cs_dec_t     dec
);
  logic fixed_ok;
  logic rm_rsvd;
  logic bad_field;

  always_comb begin
    dec.rn    = instr[19:16];
    dec.rm    = instr[3:0];
    dec.rd    = instr[11:8];
    dec.fcond = instr[7:4];
    dec.op    = cs_op_e'(instr[13:12]);
  end

  assign fixed_ok  = (instr[31:20] == HI_FIXED) && (instr[15:14] == MID_FIXED);
  assign rm_rsvd   = (instr[3:0] == IDX_RSVD);
  assign bad_field = (instr[11:8] == IDX_RSVD) || (instr[11:8] == IDX_ZERO) ||
                     (instr[19:16] == IDX_RSVD) || (instr[7:5] == 3'b111);

  // rm=13 leaves the family, so it wins over the undefined check
  assign dec.nomatch = !fixed_ok || rm_rsvd;
  assign dec.undef   = fixed_ok && !rm_rsvd && bad_field;
endmodule

// File: rtl/cs_cond.sv
module cs_cond
  import cs_pkg::*;
(
  input  logic [3:0] fcond,
  input  cs_flags_t  flags,
  output logic       pass
);
  logic base;

  // even code tests the base term, odd code its inverse
  always_comb begin
    unique case (fcond[3:1])
      3'd0: base = flags.z;
      3'd1: base = flags.c;
      3'd2: base = flags.n;
      3'd3: base = flags.v;
      3'd4: base = flags.c & ~flags.z;
      3'd5: base = (flags.n == flags.v);
      3'd6: base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
  end

  assign pass = base ^ fcond[0];
endmodule

// File: rtl/cs_alu.sv
module cs_alu
  import cs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cs_op_e           op,
  input  logic             a_zero,
  input  logic             b_zero,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic             pass,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] a_val;
  logic [DATA_W-1:0] b_val;
  logic [DATA_W-1:0] b_inv;
  logic [DATA_W-1:0] b_xf;

  assign a_val = a_zero ? '0 : a_in;
  assign b_val = b_zero ? '0 : b_in;
  assign b_inv = ~b_val;

  // negate shares the inverter: -x = ~x + 1
  always_comb begin
    unique case (op)
      OP_PASS: b_xf = b_val;
      OP_INC:  b_xf = b_val + ONE;
      OP_INV:  b_xf = b_inv;
      default: b_xf = b_inv + ONE;
    endcase
  end

  assign result = pass ? a_val : b_xf;
endmodule

// File: rtl/cs_unit.sv
module cs_unit
  import cs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [3:0]        in_flags,
  output logic [IDX_W-1:0]  rn_addr,
  output logic [IDX_W-1:0]  rm_addr,
  input  logic [DATA_W-1:0] rn_data,
  input  logic [DATA_W-1:0] rm_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_rd,
  output logic              out_wen,
  output logic              out_undef,
  output logic              out_nomatch
);
  cs_dec_t           dec;
  logic              pass;
  logic [DATA_W-1:0] alu_res;
  logic              legal;
  logic              take;

  cs_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  cs_cond u_cond (
    .fcond (dec.fcond),
    .flags (cs_flags_t'(in_flags)),
    .pass  (pass)
  );

  cs_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (dec.op),
    .a_zero (dec.rn == IDX_ZERO),
    .b_zero (dec.rm == IDX_ZERO),
    .a_in   (rn_data),
    .b_in   (rm_data),
    .pass   (pass),
    .result (alu_res)
  );

  assign rn_addr  = dec.rn;
  assign rm_addr  = dec.rm;
  assign legal    = !dec.nomatch && !dec.undef;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_wen   <= in_valid && legal;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result  <= legal ? alu_res : '0;
      out_rd      <= dec.rd;
      out_undef   <= dec.undef;
      out_nomatch <= dec.nomatch;
    end
  end

  // R11
  wen_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_valid);

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_rd) && $stable(out_wen) && $stable(out_undef) && $stable(out_nomatch)));

  // R2
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_undef && out_nomatch));

  // R3
  no_write_reserved_rd_chk: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_rd != IDX_RSVD && out_rd != IDX_ZERO && !out_undef && !out_nomatch));

  // R10
  valid_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);
endmodule

// File: tb/cs_unit_test.sv
module cs_unit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_instr, rn_data, rm_data, out_result;
  logic [3:0]  in_flags, rn_addr, rm_addr, out_rd;
  logic        out_wen, out_undef, out_nomatch;

  cs_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_flags(in_flags), .rn_addr(rn_addr), .rm_addr(rm_addr),
    .rn_data(rn_data), .rm_data(rm_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_rd(out_rd), .out_wen(out_wen),
    .out_undef(out_undef), .out_nomatch(out_nomatch)
  );

  logic [31:0] regs [16];
  assign rn_data = regs[rn_addr];
  assign rm_data = regs[rm_addr];

  typedef struct {
    logic [31:0] res;
    logic [3:0]  rd;
    logic        wen, undef, nom;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit stall_mode = 0, finished = 0;

  function automatic logic [31:0] mk(logic [1:0] op, logic [3:0] rn, logic [3:0] rd,
                                     logic [3:0] fc, logic [3:0] rm);
    return {7'b1110101, 4'b0010, 1'b1, rn, 2'b10, op, rd, fc, rm};
  endfunction

  function automatic bit cond_ok(logic [3:0] c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;          1: return !z;
      2: return cy;         3: return !cy;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return cy && !z;   9: return !cy || z;
      10: return n == v;    11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [3:0] f, string tag);
    exp_t e;
    logic [3:0] rn = w[19:16], rm = w[3:0], rd = w[11:8], fc = w[7:4];
    logic [31:0] a, b;
    bit fam = (w[31:20] == 12'hEA5) && (w[15:14] == 2'b10);
    e.tag = tag;
    e.rd = rd;
    e.nom = !fam || rm == 13;
    e.undef = !e.nom && (rd == 13 || rd == 15 || rn == 13 || fc >= 14);
    e.wen = !e.nom && !e.undef;
    a = (rn == 15) ? 32'h0 : regs[rn];
    b = (rm == 15) ? 32'h0 : regs[rm];
    case (w[13:12])
      2'd1: b = b + 32'd1;
      2'd2: b = ~b;
      2'd3: b = 32'd0 - b;
      default: ;
    endcase
    e.res = !e.wen ? 32'h0 : (cond_ok(fc, f) ? a : b);
    return e;
  endfunction

  task automatic send(logic [31:0] w, logic [3:0] f, string tag);
    in_instr = w;
    in_flags = f;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q.push_back(model(w, f, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin : monitor
    bit held = 0;
    logic [31:0] h_res;
    logic [3:0] h_rd;
    logic [2:0] h_fl;
    exp_t e;
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      out_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      if (rst) begin
        held = 0;
      end else begin
        if (held) begin
          total++;
          if (!out_valid || out_result !== h_res || out_rd !== h_rd ||
              {out_wen, out_undef, out_nomatch} !== h_fl) begin
            bad++;
            $display("FAIL R10 hold: got v=%b res=%h rd=%0d fl=%b exp v=1 res=%h rd=%0d fl=%b",
                     out_valid, out_result, out_rd, {out_wen, out_undef, out_nomatch},
                     h_res, h_rd, h_fl);
          end
        end
        held = out_valid && !out_ready;
        h_res = out_result;
        h_rd = out_rd;
        h_fl = {out_wen, out_undef, out_nomatch};
        if (out_valid && out_ready) begin
          total++;
          if (q.size() == 0) begin
            bad++;
            $display("FAIL R10 unexpected result: got res=%h exp none", out_result);
          end else begin
            e = q.pop_front();
            if (out_result !== e.res || out_rd !== e.rd || out_wen !== e.wen ||
                out_undef !== e.undef || out_nomatch !== e.nom) begin
              bad++;
              $display("FAIL %s: got res=%h rd=%0d wen=%b undef=%b nom=%b exp res=%h rd=%0d wen=%b undef=%b nom=%b",
                       e.tag, out_result, out_rd, out_wen, out_undef, out_nomatch,
                       e.res, e.rd, e.wen, e.undef, e.nom);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin : main
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 * i + 32'h0101 * (i + 3);
    regs[1] = 32'hFFFF_FFFF;
    regs[2] = 32'h8000_0000;
    regs[3] = 32'h1234_5678;
    regs[4] = 32'h0000_0005;
    regs[0] = 32'h0000_0000;
    regs[15] = 32'hDEAD_BEEF;
    rst = 1'b1;
    in_valid = 1'b1;
    in_instr = mk(2'd0, 4'd3, 4'd2, 4'd0, 4'd4);
    in_flags = 4'h0;
    repeat (3) @(negedge clk);
    total++; // R11 reset clears valid even with in_valid high
    if (out_valid !== 1'b0 || out_wen !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset: got v=%b wen=%b exp v=0 wen=0", out_valid, out_wen);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    total++; // R11 idle after reset
    if (out_valid !== 1'b0 || out_wen !== 1'b0) begin
      bad++;
      $display("FAIL R11 idle: got v=%b wen=%b exp v=0 wen=0", out_valid, out_wen);
    end
    // R4 address outputs
    in_instr = mk(2'd0, 4'd7, 4'd2, 4'd0, 4'd9);
    #1;
    total++;
    if (rn_addr !== 4'd7 || rm_addr !== 4'd9) begin
      bad++;
      $display("FAIL R4 addr: got rn=%0d rm=%0d exp rn=7 rm=9", rn_addr, rm_addr);
    end
    @(negedge clk);

    // R5..R8: each transform with condition false (EQ, Z=0) and true (Z=1)
    for (int op = 0; op < 4; op++) begin
      string t;
      t = (op == 0) ? "R5" : (op == 1) ? "R6" : (op == 2) ? "R7" : "R8";
      send(mk(2'(op), 4'd3, 4'd5, 4'd0, 4'd4), 4'b0000, {t, " cond false"});
      send(mk(2'(op), 4'd3, 4'd5, 4'd0, 4'd4), 4'b0100, {t, " cond true R9"});
    end
    send(mk(2'd1, 4'd3, 4'd6, 4'd0, 4'd1), 4'b0000, "R6 wrap");
    send(mk(2'd3, 4'd3, 4'd6, 4'd0, 4'd2), 4'b0000, "R8 min neg");
    send(mk(2'd3, 4'd3, 4'd6, 4'd0, 4'd0), 4'b0000, "R8 neg zero");
    send(mk(2'd2, 4'd3, 4'd6, 4'd0, 4'd1), 4'b0000, "R7 inv ones");
    // R4 zero index
    send(mk(2'd0, 4'd15, 4'd7, 4'd1, 4'd3), 4'b0000, "R4 rn zero");
    send(mk(2'd0, 4'd3, 4'd7, 4'd0, 4'd15), 4'b0000, "R4 rm zero");
    send(mk(2'd2, 4'd3, 4'd7, 4'd0, 4'd15), 4'b0000, "R4 R7 inv zero");
    send(mk(2'd1, 4'd3, 4'd14, 4'd0, 4'd15), 4'b0000, "R4 R6 inc zero R12");
    // R9 all codes x all flags
    for (int c = 0; c < 14; c++)
      for (int f = 0; f < 16; f++)
        send(mk(2'd0, 4'd3, 4'd8, 4'(c), 4'd4), 4'(f), "R9 cond table");
    // R3 undefined cases
    send(mk(2'd0, 4'd3, 4'd13, 4'd0, 4'd4), 4'b0000, "R3 rd13");
    send(mk(2'd0, 4'd3, 4'd15, 4'd0, 4'd4), 4'b0000, "R3 rd15");
    send(mk(2'd0, 4'd13, 4'd5, 4'd0, 4'd4), 4'b0000, "R3 rn13");
    send(mk(2'd0, 4'd3, 4'd5, 4'd14, 4'd4), 4'b0000, "R3 fc14");
    send(mk(2'd0, 4'd3, 4'd5, 4'd15, 4'd4), 4'b0100, "R3 fc15");
    // R2 rm=13 priority
    send(mk(2'd0, 4'd3, 4'd5, 4'd0, 4'd13), 4'b0000, "R2 rm13");
    send(mk(2'd1, 4'd13, 4'd15, 4'd15, 4'd13), 4'b0000, "R2 rm13 over undef");
    // R1 broken fixed bits
    send(mk(2'd0, 4'd3, 4'd5, 4'd0, 4'd4) ^ 32'h0010_0000, 4'b0000, "R1 bit20");
    send(mk(2'd0, 4'd3, 4'd5, 4'd0, 4'd4) ^ 32'h0000_4000, 4'b0000, "R1 bit14");
    send(mk(2'd0, 4'd3, 4'd5, 4'd0, 4'd4) ^ 32'h0020_0000, 4'b0000, "R1 bit21");
    send(mk(2'd0, 4'd3, 4'd5, 4'd0, 4'd4) ^ 32'h8000_0000, 4'b0000, "R1 bit31");
    send(mk(2'd0, 4'd3, 4'd5, 4'd0, 4'd4) ^ 32'h0000_8000, 4'b0000, "R1 bit15");
    // R10 back-pressure with mixed traffic
    stall_mode = 1;
    for (int i = 0; i < 120; i++)
      send(mk(2'(i % 4), 4'(i % 13), 4'(i % 12), 4'(i % 14), 4'((i * 5) % 16)),
           4'(i * 7), "R10 stalled stream R12");
    stall_mode = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule